// File: doc/BRIEF.md
# Wired Interrupt to Message Converter

This block sits between a bank of level or edge interrupt wires and a downstream interrupt translation unit that only accepts posted messages. Each message-capable wire is synchronised, turned into a pending status bit according to its programmed trigger type, and reported once as a message. The message carries a doorbell address fixed at build time, a 12-bit device identifier and a 10-bit event identifier. The two identifiers come from a per-pin vector word.

Software programs the vector words and trigger-type bits through a simple 32-bit word register port with one cycle of read latency. It acknowledges an interrupt by writing a one to the pin's bit in a status array, and that array is indexed by global pin number. Pins are banked into nodes of 128. The node count is a parameter. Global pin numbers 0 to 63 are reserved for wired use, so input `irq_in[i]` is global pin 64+i.

When several pins are pending, a rotating arbiter chooses which one to send. Each message is held on a valid/ready output until it is accepted.

Top module: `wim_converter`

## Requirements
- R1: After reset, `msg_valid` is 0, and every vector word, trigger-type word and status word reads as zero.
- R2: Pin index i has its vector word at byte address (i/128+1)*0x1000 + 0x200 + 4*(i%128). Bits 21:0 are stored and read back, and bits 31:22 read as zero. Read data appears on `reg_rdata` in the cycle after `reg_rd`.
- R3: Node n has its trigger-type words at n*0x1000 + 4*w, for w = 0..3. Bit b of word w is the type of local pin 32*w+b, and every bit reads back as written.
- R4: When a pin's type bit is 0 (rising edge), a rising edge on the synchronised input sets the pin's status and produces exactly one message. Edges that arrive while the status is set, and an input that stays high after a clear, produce no further message.
- R5: When a pin's type bit is 1 (level high), the status is set while the input is high. Clearing the status while the input stays high produces one more message.
- R6: Every message carries `msg_addr` = DOORBELL, `msg_dev` = vector bits 11:0 and `msg_evt` = vector bits 21:12 of the pin that was sent.
- R7: The status array starts at 0xA000. Global pin g = i+64 has its bit at word address 0xA000 + (g/32)*4, bit g%32. A read returns the pending bits. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R8: Status words 0 and 1, which cover global pins 0-63, always read zero and ignore writes. The node-0 window at 0x0000-0x0FFF reads zero.
- R9: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_dev` and `msg_evt` stay unchanged. `msg_valid` falls only after a cycle in which `msg_ready` was high.
- R10: Among pending, unsent pins, the next pin sent is the lowest index above the last one sent. If there is none above it, the lowest pending index is sent.
- R11: Reads of unmapped or misaligned addresses, and of node windows above NODES, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NODES*128 | Raw interrupt wires; bit i is global pin 64+i |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 16 | Byte address of the register word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Downstream accepts the message |
| msg_addr | output | 32 | Doorbell address |
| msg_dev | output | 12 | Device identifier |
| msg_evt | output | 10 | Event identifier |

## Verification
The bench builds the block with two nodes, which gives 256 message pins. With two nodes, pins in both node windows can be exercised, along with a status word that lies inside the reserved low range and a node window above the last node. A level-type pin sits in node 2 and edge-type pins sit in node 1, so the node-base arithmetic is exercised on both sides. The round-robin case is arranged so that the last-granted pointer sits in the middle of the pending set, and the pick therefore has to wrap around to the lowest index.

// File: rtl/wim_pkg.sv
package wim_pkg;
  localparam int PINS_PER_NODE = 128;
  localparam int RSVD_PINS     = 64;
  localparam int DEV_W         = 12;
  localparam int EVT_W         = 10;
  localparam int VEC_W         = DEV_W + EVT_W;
  localparam int REG_AW        = 16;
  localparam logic [3:0] STAT_PAGE = 4'hA;

  typedef enum logic [1:0] {ISS_IDLE, ISS_FETCH, ISS_SEND} iss_state_e;
  typedef enum logic [1:0] {RD_ZERO, RD_REG, RD_VEC} rd_src_e;
endpackage

// File: rtl/wim_sync.sv
module wim_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/wim_rr_arb.sv
module wim_rr_arb #(
  parameter int N  = 256,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  input  logic          adv,
  output logic          gnt_vld,
  output logic [IW-1:0] gnt_idx
);
  logic [IW-1:0] last_q;
  logic          hi_found, lo_found;
  logic [IW-1:0] hi_idx, lo_idx;

  always_comb begin
    hi_found = 1'b0;
    lo_found = 1'b0;
    hi_idx   = '0;
    lo_idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        lo_idx   = IW'(i);
        lo_found = 1'b1;
        if (i > int'(last_q)) begin
          hi_idx   = IW'(i);
          hi_found = 1'b1;
        end
      end
    end
  end

  assign gnt_vld = lo_found;
  assign gnt_idx = hi_found ? hi_idx : lo_idx;

  always_ff @(posedge clk) begin
    if (rst)      last_q <= IW'(N - 1);
    else if (adv) last_q <= gnt_idx;
  end

  assert_adv_has_req_R10: assert property (@(posedge clk) disable iff (rst)
    adv |-> gnt_vld);
endmodule

// File: rtl/wim_pin_state.sv
module wim_pin_state #(
  parameter int N  = 256,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  sync_in,
  input  logic [N-1:0]  lvl_mode,
  input  logic [N-1:0]  clr,
  input  logic          grant_vld,
  input  logic [IW-1:0] grant_idx,
  output logic [N-1:0]  status,
  output logic [N-1:0]  cand
);
  logic [N-1:0] prev_q, st_q, sent_q;

  for (genvar i = 0; i < N; i++) begin : g_pin
    logic set_c, st_d, gnt_c;
    assign set_c = lvl_mode[i] ? sync_in[i] : (sync_in[i] & ~prev_q[i]);
    assign gnt_c = grant_vld && (grant_idx == IW'(i));
    assign st_d  = (st_q[i] & ~clr[i]) | set_c;

    always_ff @(posedge clk) begin
      if (rst) begin
        prev_q[i] <= 1'b0;
        st_q[i]   <= 1'b0;
        sent_q[i] <= 1'b0;
      end else begin
        prev_q[i] <= sync_in[i];
        st_q[i]   <= st_d;
        sent_q[i] <= st_d & ((sent_q[i] & ~clr[i]) | gnt_c);
      end
    end

    assert_rise_needs_input_R4: assert property (@(posedge clk) disable iff (rst)
      $rose(st_q[i]) |-> $past(sync_in[i]));
    assert_single_send_R4: assert property (@(posedge clk) disable iff (rst)
      gnt_c |-> !sent_q[i]);
  end

  assign status = st_q;
  assign cand   = st_q & ~sent_q;
endmodule

// File: rtl/wim_converter.sv
module wim_converter
  import wim_pkg::*;
#(
  parameter int          NODES    = 2,
  parameter logic [31:0] DOORBELL = 32'h0804_0040
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NODES*128-1:0]      irq_in,
  input  logic                      reg_wr,
  input  logic                      reg_rd,
  input  logic [REG_AW-1:0]         reg_addr,
  input  logic [31:0]               reg_wdata,
  output logic [31:0]               reg_rdata,
  output logic                      msg_valid,
  input  logic                      msg_ready,
  output logic [31:0]               msg_addr,
  output logic [DEV_W-1:0]          msg_dev,
  output logic [EVT_W-1:0]          msg_evt
);
  localparam int TOTAL      = NODES * PINS_PER_NODE;
  localparam int IW         = $clog2(TOTAL);
  localparam int STAT_WORDS = (RSVD_PINS + TOTAL) / 32;
  localparam int RSVD_WORDS = RSVD_PINS / 32;

  // ---------------- synchroniser and per-pin state
  logic [TOTAL-1:0] irq_s, type_q, status, cand, clr;
  logic             adv, gnt_vld;
  logic [IW-1:0]    gnt_idx;

  wim_sync #(.W(TOTAL)) u_sync (.clk(clk), .rst(rst), .d(irq_in), .q(irq_s));

  wim_pin_state #(.N(TOTAL), .IW(IW)) u_pins (
    .clk(clk), .rst(rst), .sync_in(irq_s), .lvl_mode(type_q), .clr(clr),
    .grant_vld(adv), .grant_idx(gnt_idx), .status(status), .cand(cand));

  wim_rr_arb #(.N(TOTAL), .IW(IW)) u_arb (
    .clk(clk), .rst(rst), .req(cand), .adv(adv),
    .gnt_vld(gnt_vld), .gnt_idx(gnt_idx));

  // ---------------- address decode
  logic          is_type, is_vec, is_stat;
  logic [IW-1:0] vec_idx, type_base, stat_base;

  always_comb begin
    int  node_i, base_i, sw_i;
    logic aligned, node_ok;
    node_i    = int'(reg_addr[15:12]);
    sw_i      = int'(reg_addr[11:2]);
    aligned   = (reg_addr[1:0] == 2'b00);
    node_ok   = (node_i >= 1) && (node_i <= NODES);
    base_i    = node_ok ? (node_i - 1) * PINS_PER_NODE : 0;
    is_type   = aligned && node_ok && (reg_addr[11:4] == 8'h00);
    is_vec    = aligned && node_ok && (reg_addr[11:9] == 3'b001);
    is_stat   = aligned && (reg_addr[15:12] == STAT_PAGE) &&
                (sw_i >= RSVD_WORDS) && (sw_i < STAT_WORDS);
    vec_idx   = IW'(base_i + int'(reg_addr[8:2]));
    type_base = IW'(base_i + int'(reg_addr[3:2]) * 32);
    stat_base = is_stat ? IW'((sw_i - RSVD_WORDS) * 32) : '0;
  end

  // ---------------- trigger-type bits and status clear
  always_ff @(posedge clk) begin
    if (rst) begin
      type_q <= '0;
    end else if (reg_wr && is_type) begin
      for (int b = 0; b < 32; b++) type_q[type_base + IW'(b)] <= reg_wdata[b];
    end
  end

  always_comb begin
    clr = '0;
    if (reg_wr && is_stat)
      for (int b = 0; b < 32; b++) clr[stat_base + IW'(b)] = reg_wdata[b];
  end

  // ---------------- vector memory: one read/write port, one read port
  logic [VEC_W-1:0] vec_mem [TOTAL];
  logic [TOTAL-1:0] vld_q;
  logic [VEC_W-1:0] vec_a_q, vec_b_q;
  logic             vld_a_q, vld_b_q;

  always_ff @(posedge clk) begin
    if (reg_wr && is_vec) vec_mem[vec_idx] <= reg_wdata[VEC_W-1:0];
    if (reg_rd)           vec_a_q <= vec_mem[vec_idx];
  end

  always_ff @(posedge clk) begin
    if (adv) vec_b_q <= vec_mem[gnt_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q   <= '0;
      vld_a_q <= 1'b0;
      vld_b_q <= 1'b0;
    end else begin
      if (reg_wr && is_vec) vld_q[vec_idx] <= 1'b1;
      if (reg_rd)           vld_a_q <= vld_q[vec_idx];
      if (adv)              vld_b_q <= vld_q[gnt_idx];
    end
  end

  // ---------------- register read path
  rd_src_e     rd_src_q;
  logic [31:0] rd_reg_q, rd_type_c, rd_stat_c;

  always_comb begin
    for (int b = 0; b < 32; b++) begin
      rd_type_c[b] = type_q[type_base + IW'(b)];
      rd_stat_c[b] = status[stat_base + IW'(b)];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_src_q <= RD_ZERO;
      rd_reg_q <= '0;
    end else if (reg_rd) begin
      rd_src_q <= is_vec ? RD_VEC : ((is_type || is_stat) ? RD_REG : RD_ZERO);
      rd_reg_q <= is_type ? rd_type_c : (is_stat ? rd_stat_c : '0);
    end
  end

  always_comb begin
    case (rd_src_q)
      RD_VEC:  reg_rdata = vld_a_q ? {{(32-VEC_W){1'b0}}, vec_a_q} : '0;
      RD_REG:  reg_rdata = rd_reg_q;
      default: reg_rdata = '0;
    endcase
  end

  // ---------------- message issue
  iss_state_e st_q;
  assign adv = (st_q == ISS_IDLE) && gnt_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ISS_IDLE;
      msg_valid <= 1'b0;
      msg_dev   <= '0;
      msg_evt   <= '0;
    end else begin
      case (st_q)
        ISS_IDLE:  if (gnt_vld) st_q <= ISS_FETCH;
        ISS_FETCH: begin
          msg_dev   <= vld_b_q ? vec_b_q[DEV_W-1:0] : '0;
          msg_evt   <= vld_b_q ? vec_b_q[VEC_W-1:DEV_W] : '0;
          msg_valid <= 1'b1;
          st_q      <= ISS_SEND;
        end
        default: if (msg_ready) begin
          msg_valid <= 1'b0;
          st_q      <= ISS_IDLE;
        end
      endcase
    end
  end

  assign msg_addr = DOORBELL;

  assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !msg_valid);
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_dev) && $stable(msg_evt)));
  assert_drop_after_ready_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(msg_valid) |-> $past(msg_ready));
endmodule

// File: tb/sim_wim_converter.sv
`timescale 1ns/1ps
module sim_wim_converter;
  localparam int NODES = 2;
  localparam int TOTAL = NODES * 128;
  localparam logic [31:0] DB = 32'h0804_0040;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [TOTAL-1:0] irq_in = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0, msg_ready = 1'b1;
  logic [15:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata, msg_addr;
  logic msg_valid;
  logic [11:0] msg_dev;
  logic [9:0]  msg_evt;

  always #2 clk = ~clk;

  wim_converter #(.NODES(NODES), .DOORBELL(DB)) u0 (
    .clk(clk), .rst(rst), .irq_in(irq_in), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr),
    .msg_dev(msg_dev), .msg_evt(msg_evt));

  int vectors = 0, miscmp = 0, mon_cnt = 0;
  logic [11:0] mon_dev [64];
  logic [9:0]  mon_evt [64];
  logic [31:0] mon_addr[64];

  always @(posedge clk) begin
    if (!rst && msg_valid && msg_ready && mon_cnt < 64) begin
      mon_dev[mon_cnt]  <= msg_dev;
      mon_evt[mon_cnt]  <= msg_evt;
      mon_addr[mon_cnt] <= msg_addr;
      mon_cnt <= mon_cnt + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscmp++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] vec_addr(input int i);
    return 16'((i / 128 + 1) * 4096 + 512 + 4 * (i % 128));
  endfunction
  function automatic logic [15:0] stat_addr(input int i);
    return 16'(40960 + ((i + 64) / 32) * 4);
  endfunction
  function automatic logic [31:0] stat_bit(input int i);
    return 32'(1) << ((i + 64) % 32);
  endfunction

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_msgs(input int n);
    for (int k = 0; k < 200 && mon_cnt < n; k++) @(negedge clk);
    idle(2);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 msg_valid", {31'b0, msg_valid}, 0);
    rd(vec_addr(0), d);    chk("R1 vector", d, 0);
    rd(16'h2004, d);       chk("R1 type", d, 0);
    rd(stat_addr(0), d);   chk("R1 status", d, 0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(vec_addr(0), 32'hFFFF_FFFF);
    rd(vec_addr(0), d);    chk("R2 vector mask", d, 32'h003F_FFFF);
    wr(vec_addr(200), 32'h0012_3456);
    rd(vec_addr(200), d);  chk("R2 node2 vector", d, 32'h0012_3456);
    wr(16'h1004, 32'hA5A5_A5A5);
    rd(16'h1004, d);       chk("R3 type word", d, 32'hA5A5_A5A5);
    wr(16'h1004, 32'h0);
    rd(16'h1004, d);       chk("R3 type clear", d, 0);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    rd(16'h0200, d);       chk("R8 node0 window", d, 0);
    rd(16'h1100, d);       chk("R11 gap", d, 0);
    rd(16'h3200, d);       chk("R11 node above NODES", d, 0);
    rd(16'h1202, d);       chk("R11 misaligned", d, 0);
    rd(16'hA000 + 16'(4 * 10), d); chk("R11 status beyond", d, 0);
    wr(16'hA000, 32'hFFFF_FFFF);
    wr(16'hA004, 32'hFFFF_FFFF);
    rd(16'hA000, d);       chk("R8 reserved word0", d, 0);
    rd(16'hA004, d);       chk("R8 reserved word1", d, 0);
  endtask

  task automatic t_edge;
    logic [31:0] d;
    int base;
    wr(vec_addr(5), {10'b0, 10'h155, 12'hABC});
    base = mon_cnt;
    @(negedge clk); irq_in[5] = 1'b1;
    wait_msgs(base + 1);
    chk("R4 one message", 32'(mon_cnt - base), 1);
    chk("R6 dev", {20'b0, mon_dev[base]}, 32'hABC);
    chk("R6 evt", {22'b0, mon_evt[base]}, 32'h155);
    chk("R6 doorbell", mon_addr[base], DB);
    rd(stat_addr(5), d);   chk("R7 status bit", d, stat_bit(5));
    repeat (2) begin
      @(negedge clk); irq_in[5] = 1'b0; idle(4);
      irq_in[5] = 1'b1; idle(4);
    end
    idle(10);
    chk("R4 merged edges", 32'(mon_cnt - base), 1);
    wr(stat_addr(5), 32'h0);
    rd(stat_addr(5), d);   chk("R7 write zero no effect", d, stat_bit(5));
    wr(stat_addr(5), stat_bit(5));
    idle(10);
    rd(stat_addr(5), d);   chk("R7 clear", d, 0);
    chk("R4 held level no resend", 32'(mon_cnt - base), 1);
    @(negedge clk); irq_in[5] = 1'b0; idle(4);
  endtask

  task automatic t_level;
    logic [31:0] d;
    int base;
    wr(vec_addr(130), {10'b0, 10'h3FF, 12'h082});
    wr(16'h2000, 32'h0000_0004);
    base = mon_cnt;
    @(negedge clk); irq_in[130] = 1'b1;
    wait_msgs(base + 1);
    chk("R5 first level message", 32'(mon_cnt - base), 1);
    chk("R6 level evt", {22'b0, mon_evt[base]}, 32'h3FF);
    wr(stat_addr(130), stat_bit(130));
    wait_msgs(base + 2);
    chk("R5 retrigger after clear", 32'(mon_cnt - base), 2);
    @(negedge clk); irq_in[130] = 1'b0; idle(5);
    wr(stat_addr(130), stat_bit(130));
    idle(10);
    rd(stat_addr(130), d);  chk("R5 status after drop", d, 0);
    chk("R5 no extra message", 32'(mon_cnt - base), 2);
    wr(16'h2000, 32'h0);
  endtask

  task automatic t_hold;
    logic [11:0] dv;
    logic [9:0]  ev;
    int base;
    wr(vec_addr(40), {10'b0, 10'h0C3, 12'h028});
    base = mon_cnt;
    msg_ready = 1'b0;
    @(negedge clk); irq_in[40] = 1'b1;
    for (int k = 0; k < 50 && !msg_valid; k++) @(negedge clk);
    chk("R9 valid raised", {31'b0, msg_valid}, 1);
    dv = msg_dev; ev = msg_evt;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R9 valid held", {31'b0, msg_valid}, 1);
      chk("R9 fields stable", {10'b0, msg_evt, msg_dev}, {10'b0, ev, dv});
    end
    msg_ready = 1'b1;
    wait_msgs(base + 1);
    chk("R9 accepted once", 32'(mon_cnt - base), 1);
    chk("R9 dev", {20'b0, mon_dev[base]}, 32'h028);
    irq_in[40] = 1'b0; idle(4);
    wr(stat_addr(40), stat_bit(40));
  endtask

  task automatic t_rr;
    int base;
    wr(vec_addr(15), 32'd15);
    wr(vec_addr(3),  32'd3);
    wr(vec_addr(10), 32'd10);
    wr(vec_addr(20), 32'd20);
    base = mon_cnt;
    @(negedge clk); irq_in[15] = 1'b1;
    wait_msgs(base + 1);
    chk("R10 lone pin", {20'b0, mon_dev[base]}, 15);
    @(negedge clk); irq_in[3] = 1'b1; irq_in[10] = 1'b1; irq_in[20] = 1'b1;
    wait_msgs(base + 4);
    chk("R10 count", 32'(mon_cnt - base), 4);
    chk("R10 above last", {20'b0, mon_dev[base + 1]}, 20);
    chk("R10 wrap lowest", {20'b0, mon_dev[base + 2]}, 3);
    chk("R10 next", {20'b0, mon_dev[base + 3]}, 10);
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscmp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscmp++;
    $display("FAIL watchdog act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    idle(4);
    @(negedge clk);
    t_reset();
    rst = 1'b0;
    idle(2);
    t_reset();
    t_regs();
    t_unmapped();
    t_edge();
    t_level();
    t_hold();
    t_rr();
    idle(5);
    summary();
    $finish;
  end
endmodule